// File: doc/BRIEF.md
# Periodic Rate Generator and Interrupt Flag Unit

This block is the timing and interrupt-status corner of a real-time clock. A free-running divider advances on a strobe that arrives twice per period of a 32.768 kHz base oscillator. A rate code picks one divider stage. That stage drives a square-wave pin and raises a periodic event once per period. The periodic event joins two externally produced pulses, the alarm match and the end of a time update, in a three-source flag register.

Software programs the rate and the per-source enables through a small four-register window. It polls or services the interrupt by reading the flag register. That read returns the flags and then empties them. The interrupt line is active low and is asserted whenever a set flag has its enable on. A flag is recorded even while its enable is off, so software can poll for it.

Top module: `rtc_pirq_top`

## Requirements
- R1: After reset the rate code is 0, all enables are off, all flags are clear, `irq_n` is 1 and `sqw_out` is 0.
- R2: The register window is selected by `reg_sel`: 0 is the rate register, 1 the enable register, 2 the flag register, 3 the status register. `rdata` shows the selected register in the same cycle. In the rate register the rate code sits in bits 3:0 and the other bits read 0. In the enable register, bit 6 enables the periodic source, bit 5 the alarm, bit 4 the update-ended source and bit 3 the square wave. Bits 7 and 2:0 of the enable register read 0.
- R3: With rate code 0 the periodic flag is never set and `sqw_out` stays 0.
- R4: With rate code n from 1 to 15, the square-wave level equals bit n-1 of the count of `half_tick` strobes since reset, taken modulo 2^15. The output frequency is therefore 65536 >> n Hz at 50% duty. The periodic flag is set at each clock edge where that level goes from 0 to 1.
- R5: `sqw_out` carries the square wave only while enable bit 3 is 1. Otherwise it is 0.
- R6: In the flag register, bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag. A pulse on the source sets its flag whatever the enable. The flag stays set until the flag register is read.
- R7: Flag register bit 7 is 1 exactly when some source flag is set with its enable bit on. `irq_n` is the inverse of bit 7. Bits 3:0 of the flag register read 0.
- R8: A read strobe (`rd_en` with `reg_sel` = 2) returns the current flags in that cycle. All flags are clear from the next cycle on.
- R9: A source event in the same cycle as a flag-register read leaves that flag set after the clear.
- R10: The status register always reads 0x80. Writes to the flag register and to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One-cycle strobe at twice the 32.768 kHz base rate |
| alarm_evt | input | 1 | One-cycle alarm match pulse |
| update_evt | input | 1 | One-cycle update-ended pulse |
| reg_sel | input | 2 | Register select: 0 rate, 1 enable, 2 flags, 3 status |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; clears flags when the flag register is selected |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| sqw_out | output | 1 | Square-wave output |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench goes after the edges of the flag register. One case is an event that lands in the same cycle as the clearing read: a design that clears after setting would lose that event for good. Another is a flag raised while its enable is off: a design that gates the flag rather than the summary would then show nothing when the enable is turned on later. The rate code is run at 0, where a design that taps a stage anyway would toggle the pin and raise periodic flags. It is also run at the slowest code over two full periods, where an off-by-one stage choice would double or halve the period. Write masking on the enable register is checked, as is that writes to the flag and status registers are ignored.

// File: rtl/rtcpi_pkg.sv
package rtcpi_pkg;

   typedef enum logic [1:0] {
      SEL_RATE  = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_FLAG  = 2'd2,
      SEL_VALID = 2'd3
   } reg_sel_e;

   // bit positions shared by the enable and flag registers
   localparam int BIT_PER = 6;
   localparam int BIT_ALM = 5;
   localparam int BIT_UPD = 4;
   localparam int BIT_SQW = 3;
   localparam int BIT_SUM = 7;

   localparam logic [7:0] VALID_WORD = 8'h80;

   typedef struct packed {
      logic per;
      logic alm;
      logic upd;
   } src_t;

endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_tick,
   input  logic [RATE_W-1:0] rate,
   output logic              tap,
   output logic              p_rise
);
   localparam int NTAP  = 1 << RATE_W;
   localparam int DIV_W = NTAP - 1;

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] cnt_nx;
   logic [NTAP-1:0]  cur_tap;
   logic [NTAP-1:0]  nxt_tap;

   assign cnt_nx = cnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q <= '0;
      else if (half_tick) cnt_q <= cnt_nx;
   end

   // code 0 maps to a constant-low stage; code k taps divider bit k-1
   assign cur_tap[0] = 1'b0;
   assign nxt_tap[0] = 1'b0;
   for (genvar k = 1; k < NTAP; k++) begin : g_tap
      assign cur_tap[k] = cnt_q[k-1];
      assign nxt_tap[k] = cnt_nx[k-1];
   end

   assign tap    = cur_tap[rate];
   assign p_rise = half_tick & ~cur_tap[rate] & nxt_tap[rate];
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
   import rtcpi_pkg::*;
#(
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        reg_sel,
   input  logic [RATE_W-1:0] rate_wd,
   input  logic [3:0]        en_wd,
   output logic [RATE_W-1:0] rate_q,
   output src_t              en_q,
   output logic              sqw_en_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q   <= '0;
         en_q     <= '0;
         sqw_en_q <= 1'b0;
      end else if (wr_en) begin
         if (reg_sel == SEL_RATE) rate_q <= rate_wd;
         if (reg_sel == SEL_CTRL) begin
            en_q.per <= en_wd[3];
            en_q.alm <= en_wd[2];
            en_q.upd <= en_wd[1];
            sqw_en_q <= en_wd[0];
         end
      end
   end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
   import rtcpi_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  src_t set_src,
   input  logic clr,
   input  src_t en,
   output src_t flags_q,
   output logic summary
);
   src_t flags_d;

   // clear first, then merge this cycle's events so none is lost
   always_comb begin
      flags_d = clr ? src_t'('0) : flags_q;
      flags_d = flags_d | set_src;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign summary = |(flags_q & en);
endmodule

// File: rtl/rtc_pirq_top.sv
module rtc_pirq_top
   import rtcpi_pkg::*;
#(
   parameter int RATE_W      = 4,
   parameter bit SQW_OUT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       half_tick,
   input  logic       alarm_evt,
   input  logic       update_evt,
   input  logic [1:0] reg_sel,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       sqw_out,
   output logic       irq_n
);
   if (RATE_W < 2 || RATE_W > 4) begin : g_bad_rate_w
      $error("rtc_pirq_top: RATE_W must lie in 2..4");
   end

   logic [RATE_W-1:0] rate_q;
   src_t              en_q;
   logic              sqw_en_q;
   logic              tap;
   logic              p_rise;
   src_t              set_src;
   src_t              flags_q;
   logic              summary;
   logic              rd_c;
   logic [2:0]        flag_bits;
   logic              sqw_comb;
   logic              unused_wdata_msb;

   assign unused_wdata_msb = wdata[7];

   rtc_ctrl_regs #(.RATE_W(RATE_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .reg_sel  (reg_sel),
      .rate_wd  (wdata[RATE_W-1:0]),
      .en_wd    (wdata[6:3]),
      .rate_q   (rate_q),
      .en_q     (en_q),
      .sqw_en_q (sqw_en_q)
   );

   rtc_rate_div #(.RATE_W(RATE_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_tick (half_tick),
      .rate      (rate_q),
      .tap       (tap),
      .p_rise    (p_rise)
   );

   assign rd_c        = rd_en && (reg_sel == SEL_FLAG);
   assign set_src.per = p_rise;
   assign set_src.alm = alarm_evt;
   assign set_src.upd = update_evt;

   rtc_irq_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_src (set_src),
      .clr     (rd_c),
      .en      (en_q),
      .flags_q (flags_q),
      .summary (summary)
   );

   assign flag_bits = flags_q;
   assign irq_n     = ~summary;
   assign sqw_comb  = sqw_en_q & tap;

   if (SQW_OUT_REG) begin : g_sqw_reg
      logic sqw_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sqw_q <= 1'b0;
         else        sqw_q <= sqw_comb;
      end
      assign sqw_out = sqw_q;
   end else begin : g_sqw_comb
      assign sqw_out = sqw_comb;
   end

   always_comb begin
      rdata = '0;
      unique case (reg_sel)
         SEL_RATE:  rdata[RATE_W-1:0] = rate_q;
         SEL_CTRL: begin
            rdata[BIT_PER] = en_q.per;
            rdata[BIT_ALM] = en_q.alm;
            rdata[BIT_UPD] = en_q.upd;
            rdata[BIT_SQW] = sqw_en_q;
         end
         SEL_FLAG: begin
            rdata[BIT_SUM] = summary;
            rdata[BIT_PER] = flags_q.per;
            rdata[BIT_ALM] = flags_q.alm;
            rdata[BIT_UPD] = flags_q.upd;
         end
         default:   rdata = VALID_WORD;
      endcase
   end
endmodule

// File: rtl/rtc_pirq_chk.sv
module rtc_pirq_chk #(
   parameter int RATE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              half_tick,
   input logic              alarm_evt,
   input logic              update_evt,
   input logic              rd_en,
   input logic [1:0]        reg_sel,
   input logic [7:0]        rdata,
   input logic [RATE_W-1:0] rate_q,
   input logic              p_rise,
   input logic [2:0]        flag_bits
);
   logic rd_c;
   assign rd_c = rd_en && (reg_sel == 2'd2);

   assert_rate0_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q == '0) |=> !$rose(flag_bits[2]));

   assert_rise_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_bits[2]) |-> $past(half_tick));

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_bits[1] && !rd_c) |=> flag_bits[1]);

   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_c && !alarm_evt && !update_evt && !p_rise) |=> (flag_bits == 3'b000));

   assert_keep_coincident_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_c && update_evt) |=> flag_bits[0]);

   assert_status_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd3) |-> (rdata == 8'h80));
endmodule

bind rtc_pirq_top rtc_pirq_chk #(.RATE_W(RATE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .half_tick  (half_tick),
   .alarm_evt  (alarm_evt),
   .update_evt (update_evt),
   .rd_en      (rd_en),
   .reg_sel    (reg_sel),
   .rdata      (rdata),
   .rate_q     (rate_q),
   .p_rise     (p_rise),
   .flag_bits  (flag_bits)
);

// File: tb/tb_rtc_pirq_top.sv
module tb_rtc_pirq_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       half_tick = 1'b0;
   logic       alarm_evt = 1'b0;
   logic       update_evt = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       sqw_out;
   logic       irq_n;

   int n_cmp  = 0;
   int n_fail = 0;
   int cycles = 0;

   // reference state
   int m_rate = 0;
   int m_en   = 0;
   int m_cnt  = 0;
   int m_flag = 0;   // bit6 P, bit5 A, bit4 U

   always #4 clk = ~clk;

   rtc_pirq_top dut (
      .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
      .alarm_evt(alarm_evt), .update_evt(update_evt),
      .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .sqw_out(sqw_out), .irq_n(irq_n)
   );

   function automatic int bit_of(int v, int b);
      return (v >> b) & 1;
   endfunction

   function automatic int exp_sum();
      return ((m_flag & m_en & 8'h70) != 0) ? 1 : 0;
   endfunction

   function automatic int exp_sqw();
      if (m_rate == 0 || bit_of(m_en, 3) == 0) return 0;
      return bit_of(m_cnt, m_rate - 1);
   endfunction

   function automatic int exp_rdata(int sel);
      case (sel)
         0: return m_rate;
         1: return m_en;
         2: return (exp_sum() << 7) | m_flag;
         default: return 8'h80;
      endcase
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_rate = 0; m_en = 0; m_cnt = 0; m_flag = 0;
      end else begin
         int nc;
         int setp;
         setp = 0;
         if (half_tick) begin
            nc = (m_cnt + 1) & 32'h7FFF;
            if (m_rate != 0 && bit_of(m_cnt, m_rate - 1) == 0 && bit_of(nc, m_rate - 1) == 1)
               setp = 1;
            m_cnt = nc;
         end
         if (rd_en && reg_sel == 2'd2) m_flag = 0;
         if (setp) m_flag |= 8'h40;
         if (alarm_evt) m_flag |= 8'h20;
         if (update_evt) m_flag |= 8'h10;
         if (wr_en && reg_sel == 2'd0) m_rate = int'(wdata) & 15;
         if (wr_en && reg_sel == 2'd1) m_en = int'(wdata) & 8'h78;
      end
   end

   task automatic cmp(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // drive one cycle at the falling edge, then check settled outputs
   task automatic step(string tag, bit ht, bit ae, bit ue, bit rd, bit wr,
                       logic [1:0] sel, logic [7:0] wd);
      @(negedge clk);
      half_tick = ht; alarm_evt = ae; update_evt = ue;
      rd_en = rd; wr_en = wr; reg_sel = sel; wdata = wd;
      #1;
      cmp({tag, " rdata"}, int'(rdata), exp_rdata(int'(sel)));
      cmp("R5 sqw_out", int'(sqw_out), exp_sqw());
      cmp("R7 irq_n", int'(irq_n), 1 - exp_sum());
   endtask

   task automatic idle(string tag, logic [1:0] sel);
      step(tag, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, sel, 8'h00);
   endtask

   task automatic wr(logic [1:0] sel, logic [7:0] wd);
      step("R2 write", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, sel, wd);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      idle("R1 rate", 2'd0);
      idle("R1 enables", 2'd1);
      idle("R1 flags", 2'd2);
      cmp("R1 irq_n", int'(irq_n), 1);
      cmp("R1 sqw_out", int'(sqw_out), 0);

      // R2 write masking and readback
      wr(2'd0, 8'hFF);
      idle("R2 rate readback", 2'd0);
      cmp("R2 rate value", int'(rdata), 8'h0F);
      wr(2'd1, 8'hFF);
      idle("R2 enable readback", 2'd1);
      cmp("R2 enable value", int'(rdata), 8'h78);
      wr(2'd1, 8'h00);
      idle("R7 flags with enables off", 2'd2);
      step("R8 clear", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 8'h00);

      // R3 rate zero: no toggling, no periodic flag
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h48);
      for (int i = 0; i < 200; i++) step("R3 rate0", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00);
      cmp("R3 no periodic flag", int'(rdata), 8'h00);

      // R4 fast rates
      for (int r = 1; r <= 4; r++) begin
         wr(2'd0, 8'(r));
         for (int i = 0; i < 64; i++) step("R4 rate run", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00);
      end
      step("R8 clear", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 8'h00);

      // R6/R7: flag recorded while disabled, summary once enabled
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      step("R6 alarm pulse", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00);
      idle("R6 alarm flag disabled", 2'd2);
      cmp("R6 flag value", int'(rdata), 8'h20);
      cmp("R7 irq idle", int'(irq_n), 1);
      wr(2'd1, 8'h20);
      idle("R7 summary enabled", 2'd2);
      cmp("R7 summary value", int'(rdata), 8'hA0);
      cmp("R7 irq asserted", int'(irq_n), 0);

      // R8 read returns then clears
      step("R8 read", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 8'h00);
      cmp("R8 read value", int'(rdata), 8'hA0);
      idle("R8 after read", 2'd2);
      cmp("R8 cleared", int'(rdata), 8'h00);

      // R9 event coinciding with read
      step("R9 read+event", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 8'h00);
      idle("R9 after", 2'd2);
      cmp("R9 kept", int'(rdata), 8'h10);

      // R10 ignored writes, status word
      step("R10 write flags", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 8'hFF);
      idle("R10 flags unchanged", 2'd2);
      cmp("R10 flags value", int'(rdata), 8'h10);
      step("R10 write status", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 8'h00);
      idle("R10 status", 2'd3);
      cmp("R10 status value", int'(rdata), 8'h80);
      step("R8 clear", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 8'h00);

      // R4 slowest rate over two periods
      wr(2'd0, 8'h0F);
      wr(2'd1, 8'h48);
      for (int i = 0; i < 66000; i++) begin
         bit rd;
         rd = (i % 5000) == 4999;
         step("R4 rate15", 1'b1, 1'b0, 1'b0, rd, 1'b0, 2'd2, 8'h00);
      end

      // random mix
      for (int i = 0; i < 40000; i++) begin
         logic [1:0] sel;
         bit w;
         logic [7:0] d;
         sel = 2'($urandom_range(0, 3));
         w = ($urandom_range(0, 99) < 3);
         d = 8'($urandom);
         if (w && sel == 2'd0) d = 8'($urandom_range(0, 9));
         step("R6 random", ($urandom_range(0, 3) != 0), ($urandom_range(0, 99) < 2),
              ($urandom_range(0, 99) < 2), ($urandom_range(0, 99) < 4), w, sel, d);
      end

      finish_run();
   end
endmodule